// File: doc/BRIEF.md
# Interrupt Entry Bus Sequencer

This block steps a 16-bit, 6502-family style processor core through its bus cycles when the core takes an interrupt. The core raises a single-cycle start pulse and, in that cycle, presents its program bank, program counter, status byte, emulation flag, stack pointer and the 16-bit vector address (which always lies in bank 0x00). From the next cycle on, the sequencer issues one bus operation per clock. It first does a throwaway read at the interrupted bank:PC without advancing it. An internal cycle follows. It then pushes the return state onto the stack and fetches the two vector bytes. When the last byte arrives, the new program counter, bank, status and stack pointer appear on the outputs, together with a one-cycle done pulse.

The state machine has nine states. IDLE goes to DUMMY on an accepted start. DUMMY goes to INTERNAL. INTERNAL goes to PUSH_BANK in native mode and to PUSH_PCH in emulation mode. PUSH_BANK goes to PUSH_PCH, PUSH_PCH to PUSH_PCL, PUSH_PCL to PUSH_STAT, and PUSH_STAT to VEC_LO. VEC_LO goes to VEC_HI, and VEC_HI returns to IDLE. While in IDLE the block also serves the core's two-cycle implied opcodes. When the core asks for their closing internal cycle and an interrupt is already pending, that cycle is issued as a bus read at bank:PC instead.

Top module: `irq_entry_seq`

## Requirements
- R1: During and right after reset the block is in IDLE. bus_rd, bus_wr, busy and done are all 0.
- R2: A start accepted in IDLE produces a read at {pbr_in, pc_in} in the next cycle (bus_rd=1, bus_wr=0). The returned byte is discarded and the PC is not advanced.
- R3: The cycle after the dummy read is internal: bus_rd=0 and bus_wr=0.
- R4: In native mode (emu_in=0) the third cycle writes the program bank byte to {0x00, SP}. In emulation mode this push does not occur. Every push writes at the current SP, and SP is decremented afterwards.
- R5: The pushes continue in this order: PC[15:8], then PC[7:0], then the status byte. Each goes to an address one below the previous one.
- R6: The pushed status equals p_in in native mode. In emulation mode it equals p_in with bit 4 forced to 0.
- R7: In emulation mode SP[15:8] is held at 0x01 and SP[7:0] wraps from 0x00 to 0xFF. In native mode all 16 bits decrement.
- R8: After the pushes come a read at {0x00, vec} (low byte) and then a read at {0x00, vec+1} (high byte, with 16-bit wrap). One cycle after the high read, done is 1 for exactly one cycle and pc_out = {high, low}.
- R9: By the high-byte read cycle, pbr_out is already 0x00 and p_out is p_in with bit 2 (interrupt disable) set and bit 3 (decimal) cleared. The other bits are unchanged.
- R10: A start that arrives while busy is ignored. The running sequence and its results are unaffected.
- R11: In IDLE with io_req=1, the cycle is a read at {pbr_in, pc_in} if irq_pending=1 and an internal cycle otherwise. With io_req=0 there is no bus operation.
- R12: bus_rd and bus_wr are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Interrupt entry request pulse |
| io_req | input | 1 | Core requests the closing internal cycle of a 2-cycle opcode |
| irq_pending | input | 1 | An interrupt will be taken after the current opcode |
| pbr_in | input | 8 | Current program bank |
| pc_in | input | 16 | Current program counter |
| p_in | input | 8 | Current status byte |
| emu_in | input | 1 | Emulation mode flag |
| sp_in | input | 16 | Current stack pointer |
| vec_in | input | 16 | Vector address in bank 0x00 |
| bus_addr | output | 24 | Bus address |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, sampled in the same cycle |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| pc_out | output | 16 | New program counter |
| pbr_out | output | 8 | New program bank |
| p_out | output | 8 | New status byte |
| sp_out | output | 16 | Stack pointer after the pushes |

## Verification
The assertions check four things on every cycle: that read and write are exclusive, that every push lowers the stack pointer's low byte by one, that the stack page stays pinned in emulation mode, and that done lasts a single cycle. They also check that the bank and flags are already updated in the high-vector cycle and that captured inputs hold still while busy. Only the bench's scenarios can show the exact cycle order and addresses of each sequence, with and without the bank push. The same holds for the emulation-mode status masking, the stack low-byte wrap and the vector-address wrap. The final PC assembled from returned bytes and the rejection of a mid-sequence start also need the scenarios. So does the pending-interrupt conversion of an idle internal cycle.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
    typedef enum logic [3:0] {
        S_IDLE,
        S_DUMMY,
        S_INTERNAL,
        S_PUSH_BANK,
        S_PUSH_PCH,
        S_PUSH_PCL,
        S_PUSH_STAT,
        S_VEC_LO,
        S_VEC_HI
    } seq_state_e;

    localparam int unsigned BRK_BIT = 4;
    localparam int unsigned IRQ_DIS_BIT = 2;
    localparam int unsigned DEC_BIT = 3;
endpackage

// File: rtl/irq_seq_sp.sv
module irq_seq_sp #(
    parameter int unsigned DW = 8,
    parameter logic [DW-1:0] EMU_PAGE = 8'h01
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [2*DW-1:0] load_val,
    input  logic            emu,
    input  logic            dec,
    output logic [2*DW-1:0] sp
);
    localparam int unsigned SPW = 2 * DW;

    logic [SPW-1:0] sp_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sp_q <= '0;
        end else if (load) begin
            sp_q <= emu ? {EMU_PAGE, load_val[DW-1:0]} : load_val;
        end else if (dec) begin
            if (emu) sp_q <= {EMU_PAGE, sp_q[DW-1:0] - 1'b1};
            else     sp_q <= sp_q - 1'b1;
        end
    end

    assign sp = sp_q;

    // R7: stack page pinned in emulation mode after any update
    p_emu_page_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (emu && (load || dec)) |=> sp_q[SPW-1:DW] == EMU_PAGE);
endmodule

// File: rtl/irq_seq_pushsel.sv
module irq_seq_pushsel
    import irq_seq_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  seq_state_e      state,
    input  logic [DW-1:0]   bank,
    input  logic [2*DW-1:0] pc,
    input  logic [DW-1:0]   status,
    input  logic            emu,
    output logic [DW-1:0]   byte_out
);
    logic [DW-1:0] stat_masked;

    always_comb begin
        stat_masked = status;
        if (emu) stat_masked[BRK_BIT] = 1'b0;
    end

    always_comb begin
        unique case (state)
            S_PUSH_BANK: byte_out = bank;
            S_PUSH_PCH:  byte_out = pc[2*DW-1:DW];
            S_PUSH_PCL:  byte_out = pc[DW-1:0];
            S_PUSH_STAT: byte_out = stat_masked;
            default:     byte_out = '0;
        endcase
    end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_seq_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            io_req,
    input  logic            irq_pending,
    input  logic [7:0]      pbr_in,
    input  logic [15:0]     pc_in,
    input  logic [7:0]      p_in,
    input  logic            emu_in,
    input  logic [15:0]     sp_in,
    input  logic [15:0]     vec_in,
    output logic [23:0]     bus_addr,
    output logic            bus_rd,
    output logic            bus_wr,
    output logic [7:0]      bus_wdata,
    input  logic [7:0]      bus_rdata,
    output logic            busy,
    output logic            done,
    output logic [15:0]     pc_out,
    output logic [7:0]      pbr_out,
    output logic [7:0]      p_out,
    output logic [15:0]     sp_out
);
    localparam int unsigned PCW = 2 * DW;
    localparam logic [DW-1:0] ZERO_BANK = '0;

    seq_state_e state_q, state_d;

    logic [DW-1:0]  cap_pbr, cap_p, vlo_q, pbr_q, p_q;
    logic [PCW-1:0] cap_pc, cap_vec, pc_q, sp;
    logic           cap_emu, done_q;
    logic           accept, push_now;
    logic [DW-1:0]  push_byte;

    assign accept   = (state_q == S_IDLE) && start;
    assign push_now = (state_q == S_PUSH_BANK) || (state_q == S_PUSH_PCH) ||
                      (state_q == S_PUSH_PCL)  || (state_q == S_PUSH_STAT);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:      if (start) state_d = S_DUMMY;
            S_DUMMY:     state_d = S_INTERNAL;
            S_INTERNAL:  state_d = cap_emu ? S_PUSH_PCH : S_PUSH_BANK;
            S_PUSH_BANK: state_d = S_PUSH_PCH;
            S_PUSH_PCH:  state_d = S_PUSH_PCL;
            S_PUSH_PCL:  state_d = S_PUSH_STAT;
            S_PUSH_STAT: state_d = S_VEC_LO;
            S_VEC_LO:    state_d = S_VEC_HI;
            S_VEC_HI:    state_d = S_IDLE;
            default:     state_d = S_IDLE;
        endcase
    end

    // captured context and results
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_pbr <= '0; cap_pc <= '0; cap_p <= '0; cap_emu <= 1'b0;
            cap_vec <= '0; vlo_q <= '0; pc_q <= '0; pbr_q <= '0;
            p_q <= '0; done_q <= 1'b0;
        end else begin
            done_q <= (state_q == S_VEC_HI);
            if (accept) begin
                cap_pbr <= pbr_in;
                cap_pc  <= pc_in;
                cap_p   <= p_in;
                cap_emu <= emu_in;
                cap_vec <= vec_in;
                pbr_q   <= pbr_in;
                p_q     <= p_in;
            end
            if (state_q == S_VEC_LO) begin
                vlo_q          <= bus_rdata;
                pbr_q          <= ZERO_BANK;
                p_q[IRQ_DIS_BIT] <= 1'b1;
                p_q[DEC_BIT]     <= 1'b0;
            end
            if (state_q == S_VEC_HI) pc_q <= {bus_rdata, vlo_q};
        end
    end

    irq_seq_sp #(.DW(DW)) u_sp (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (sp_in),
        .emu      (accept ? emu_in : cap_emu),
        .dec      (push_now),
        .sp       (sp)
    );

    irq_seq_pushsel #(.DW(DW)) u_push (
        .state    (state_q),
        .bank     (cap_pbr),
        .pc       (cap_pc),
        .status   (cap_p),
        .emu      (cap_emu),
        .byte_out (push_byte)
    );

    // bus outputs per state
    always_comb begin
        bus_rd    = 1'b0;
        bus_wr    = 1'b0;
        bus_addr  = '0;
        bus_wdata = '0;
        unique case (state_q)
            S_IDLE: if (io_req && irq_pending) begin
                bus_rd   = 1'b1;
                bus_addr = {pbr_in, pc_in};
            end
            S_DUMMY: begin
                bus_rd   = 1'b1;
                bus_addr = {cap_pbr, cap_pc};
            end
            S_INTERNAL: ;
            S_PUSH_BANK, S_PUSH_PCH, S_PUSH_PCL, S_PUSH_STAT: begin
                bus_wr    = 1'b1;
                bus_addr  = {ZERO_BANK, sp};
                bus_wdata = push_byte;
            end
            S_VEC_LO: begin
                bus_rd   = 1'b1;
                bus_addr = {ZERO_BANK, cap_vec};
            end
            S_VEC_HI: begin
                bus_rd   = 1'b1;
                bus_addr = {ZERO_BANK, cap_vec + 1'b1};
            end
            default: ;
        endcase
    end

    assign busy    = (state_q != S_IDLE);
    assign done    = done_q;
    assign pc_out  = pc_q;
    assign pbr_out = pbr_q;
    assign p_out   = p_q;
    assign sp_out  = sp;

    p_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_rd && bus_wr));
    p_push_dec_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |=> sp[DW-1:0] == $past(sp[DW-1:0]) - 1'b1);
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_VEC_HI) |-> (pbr_out == ZERO_BANK && p_out[IRQ_DIS_BIT] && !p_out[DEC_BIT]));
    p_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_IDLE) |=> ($stable(cap_pc) && $stable(cap_vec)));
    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !io_req) |-> (!bus_rd && !bus_wr));
endmodule

// File: tb/tb_irq_entry_seq.sv
module tb_irq_entry_seq;
    localparam time PERIOD = 10ns;

    logic clk = 1'b0, rst_n = 1'b0;
    logic start = 0, io_req = 0, irq_pending = 0, emu_in = 0;
    logic [7:0]  pbr_in = 0, p_in = 0, bus_rdata = 0;
    logic [15:0] pc_in = 0, sp_in = 0, vec_in = 0;
    logic [23:0] bus_addr;
    logic bus_rd, bus_wr, busy, done;
    logic [7:0]  bus_wdata, pbr_out, p_out;
    logic [15:0] pc_out, sp_out;

    int checks = 0, errors = 0;

    irq_entry_seq dut (.*);

    always #(PERIOD/2) clk = ~clk;

    typedef struct {
        logic        rd, wr, chkf;
        logic [23:0] addr;
        logic [7:0]  wd, rdv, pexp;
        string       tag;
    } item_t;

    item_t expq[$];

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops one expected bus op per cycle
    always @(negedge clk) begin
        if (expq.size() != 0) begin
            item_t it;
            it = expq.pop_front();
            bus_rdata <= it.rdv;
            chk(bus_rd == it.rd && bus_wr == it.wr, {it.tag, " strobes"},
                {30'd0, bus_rd, bus_wr}, {30'd0, it.rd, it.wr});
            if (it.rd || it.wr)
                chk(bus_addr == it.addr, {it.tag, " addr"}, {8'd0, bus_addr}, {8'd0, it.addr});
            if (it.wr)
                chk(bus_wdata == it.wd, {it.tag, " wdata"}, {24'd0, bus_wdata}, {24'd0, it.wd});
            if (it.chkf)
                chk(pbr_out == 8'h00 && p_out == it.pexp, "R9 flags at high read",
                    {16'd0, pbr_out, p_out}, {24'd0, it.pexp});
        end
    end

    function automatic logic [15:0] spdec(input logic e, input logic [15:0] s);
        return e ? {8'h01, s[7:0] - 8'd1} : s - 16'd1;
    endfunction

    function automatic item_t mk(input logic rd, input logic wr, input logic [23:0] a,
                                 input logic [7:0] wd, input logic [7:0] rdv, input string tag);
        item_t it;
        it.rd = rd; it.wr = wr; it.addr = a; it.wd = wd; it.rdv = rdv;
        it.chkf = 1'b0; it.pexp = 8'h00; it.tag = tag;
        return it;
    endfunction

    task automatic run_seq(input logic e, input logic [7:0] pb, input logic [15:0] pc,
                           input logic [7:0] p, input logic [15:0] sp, input logic [15:0] vec,
                           input logic [7:0] lo, input logic [7:0] hi, input bit poke);
        logic [15:0] s;
        logic [7:0] pst, pn;
        item_t it;
        @(negedge clk);
        emu_in = e; pbr_in = pb; pc_in = pc; p_in = p; sp_in = sp; vec_in = vec;
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        s = e ? {8'h01, sp[7:0]} : sp;
        pst = e ? (p & 8'hEF) : p;
        pn = (p | 8'h04) & 8'hF7;
        expq.push_back(mk(1, 0, {pb, pc}, 0, 8'h5A, "R2 dummy read"));
        expq.push_back(mk(0, 0, 0, 0, 0, "R3 internal"));
        if (!e) begin
            expq.push_back(mk(0, 1, {8'h00, s}, pb, 0, "R4 bank push"));
            s = spdec(e, s);
        end
        expq.push_back(mk(0, 1, {8'h00, s}, pc[15:8], 0, "R5 pch push"));
        s = spdec(e, s);
        expq.push_back(mk(0, 1, {8'h00, s}, pc[7:0], 0, "R5 pcl push"));
        s = spdec(e, s);
        expq.push_back(mk(0, 1, {8'h00, s}, pst, 0, "R6 status push"));
        s = spdec(e, s);
        expq.push_back(mk(1, 0, {8'h00, vec}, 0, lo, "R8 vector low"));
        it = mk(1, 0, {8'h00, vec + 16'd1}, 0, hi, "R8 vector high");
        it.chkf = 1'b1; it.pexp = pn;
        expq.push_back(it);
        if (poke) begin
            // R10: a second start mid-sequence must not disturb anything
            @(negedge clk); @(negedge clk);
            pbr_in = 8'hEE; pc_in = 16'hDEAD; vec_in = 16'h1234; sp_in = 16'h0555;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        wait (expq.size() == 0);
        @(negedge clk);
        chk(done == 1'b1, "R8 done pulse", {31'd0, done}, 32'd1);
        chk(pc_out == {hi, lo}, "R8 new pc", {16'd0, pc_out}, {16'd0, hi, lo});
        chk(pbr_out == 8'h00 && p_out == pn, "R9 final bank/status",
            {16'd0, pbr_out, p_out}, {24'd0, pn});
        chk(sp_out == s, e ? "R7 final sp emulation" : "R4 final sp native",
            {16'd0, sp_out}, {16'd0, s});
        chk(!busy, poke ? "R10 idle after ignored start" : "R8 idle after",
            {31'd0, busy}, 32'd0);
        @(negedge clk);
        chk(done == 1'b0 && !bus_rd && !bus_wr, "R8 done single cycle",
            {29'd0, done, bus_rd, bus_wr}, 32'd0);
    endtask

    initial begin
        #(PERIOD * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(PERIOD * 2);
        @(negedge clk);
        chk(!bus_rd && !bus_wr && !busy && !done, "R1 reset state",
            {28'd0, bus_rd, bus_wr, busy, done}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!bus_rd && !bus_wr && !busy && !done, "R1 after reset",
            {28'd0, bus_rd, bus_wr, busy, done}, 32'd0);

        // R11: idle internal-cycle conversion
        pbr_in = 8'h7E; pc_in = 16'h8123; io_req = 1'b1; irq_pending = 1'b0;
        #1;
        chk(!bus_rd && !bus_wr, "R11 io without pending", {30'd0, bus_rd, bus_wr}, 32'd0);
        irq_pending = 1'b1;
        #1;
        chk(bus_rd && !bus_wr && bus_addr == 24'h7E8123, "R11 io with pending",
            {7'd0, bus_rd, bus_addr}, {7'd0, 1'b1, 24'h7E8123});
        io_req = 1'b0;
        #1;
        chk(!bus_rd && !bus_wr, "R11 no request", {30'd0, bus_rd, bus_wr}, 32'd0);
        irq_pending = 1'b0;

        // native, stack crosses a page, status with bit 4 and D set
        run_seq(1'b0, 8'h12, 16'h3456, 8'h38, 16'h2001, 16'hFFEE, 8'hCD, 8'hAB, 1'b0);
        // emulation, stack low byte wraps, bit 4 masked
        run_seq(1'b1, 8'h00, 16'hC0DE, 8'h3C, 16'h0101, 16'hFFFE, 8'h34, 8'h12, 1'b0);
        // native, vector address wraps, mid-sequence start ignored (R10)
        run_seq(1'b0, 8'hFF, 16'h00FF, 8'h10, 16'h01FF, 16'hFFFF, 8'h00, 8'hE0, 1'b1);
        // emulation with mid-sequence start (R7, R10)
        run_seq(1'b1, 8'h00, 16'hFFFF, 8'hFF, 16'h01FE, 16'h0200, 8'h99, 8'h88, 1'b1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule